// File: doc/BRIEF.md
# Host transmit queue frame dispatcher

The dispatcher sits between a host-written transmit queue and the switch egress. The host pushes frames as a stream of 16-bit words over a valid/ready handshake. The first word of a frame is a control word and the second holds the byte count. The packet words follow, with the lower byte of each word sent first. The block decodes the control word and emits exactly the counted number of bytes on an 8-bit valid/ready egress stream. Each byte carries a two-bit port selection, and the final byte carries a last marker.

The two-bit mask in the control word picks the egress. It can name port 1 only, port 2 only, or both ports. A zero mask leaves the choice to an external address-lookup result. That result is captured once the destination address, the first six bytes, has gone out. For a frame shorter than six bytes, it is captured on the final byte.

When a frame finishes, its 6-bit identifier is placed in a status register. If the control word asked for it, a one-cycle completion interrupt is raised. A frame whose byte count is zero sends nothing and sets a sticky error flag. The frames after it are handled normally. Packet contents, including addresses and the length/type field, pass through untouched.

Top module: `tx_frame_dispatch`

## Requirements
- R1: Words are accepted on cycles where host_valid and host_ready are both high. The order is control word, count word, then ceil(count/2) data words. While a data word is waiting to be sent, host_ready is low.
- R2: Each data word sends bits 7:0 first and then bits 15:8. For an odd count, the high byte of the final word is never sent.
- R3: Exactly count bytes leave on eg_byte for each frame. eg_last is high on the final counted byte only.
- R4: With control bits 9:8 = 01, eg_port is 01 on every byte. With 10 it is 10, and with 11 it is 11.
- R5: With control bits 9:8 = 00, lkp_port is captured on the handshake of byte index min(5, count-1). eg_port equals the captured value on every later byte and on the last byte.
- R6: In the cycle after the last-byte handshake, tx_status holds control bits 5:0. At no other time does tx_status change.
- R7: tx_irq is high for exactly the one cycle after a last-byte handshake, and only when control bit 15 was set.
- R8: A count field (bits 10:0) of zero sends no bytes. It leaves tx_status unchanged, raises no interrupt, and sets cnt_err. cnt_err stays set until reset, and the next frame is processed normally.
- R9: Control bits 14:10 and 7:6, and count-word bits 15:11, have no effect on the output.
- R10: While eg_valid is high and eg_ready is low, eg_valid stays high and eg_byte and eg_last stay unchanged.
- R11: After reset, host_ready is 1 and eg_valid, tx_irq, tx_status and cnt_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host word valid |
| host_ready | output | 1 | Block can take a host word |
| host_word | input | 16 | Host queue word |
| lkp_port | input | 2 | Port result from external address lookup |
| eg_valid | output | 1 | Egress byte valid |
| eg_ready | input | 1 | Egress accepts byte |
| eg_byte | output | 8 | Egress byte |
| eg_last | output | 1 | Final byte of frame |
| eg_port | output | 2 | Destination port selection (bit 0 port 1, bit 1 port 2) |
| tx_status | output | 6 | Identifier of the last completed frame |
| tx_irq | output | 1 | Completion interrupt pulse |
| cnt_err | output | 1 | Sticky zero-count error |

## Verification
The bench targets the byte counts near the address boundary: 1, 2, 5, 6, 7 and an 11-bit maximum of 2047. A design that captured the lookup at the wrong index, or only at index 5, would report a port taken from a changing input. Odd counts check that the spare high byte never leaks out, and an off-by-one counter would move eg_last or drop a byte. A zero-count frame placed in the stream checks that no bytes, status update or interrupt follow it, and that the next frame is still framed correctly. Frames with reserved bits randomly set would expose a decoder that read the wrong bit field.

// File: rtl/tx_frame_dispatch.sv
module tx_frame_dispatch #(
  parameter int CNT_W  = 11,
  parameter int ID_W   = 6,
  parameter int DA_LEN = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_valid,
  output logic            host_ready,
  input  logic [15:0]     host_word,
  input  logic [1:0]      lkp_port,
  output logic            eg_valid,
  input  logic            eg_ready,
  output logic [7:0]      eg_byte,
  output logic            eg_last,
  output logic [1:0]      eg_port,
  output logic [ID_W-1:0] tx_status,
  output logic            tx_irq,
  output logic            cnt_err
);

  localparam int IRQ_BIT = 15;
  localparam int MASK_LO = 8;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] DA_END = CNT_W'(DA_LEN - 1);

  typedef enum logic [1:0] {S_CTRL, S_CNT, S_DATA} st_t;

  st_t             st;
  logic            req_irq;
  logic [1:0]      mask;
  logic [ID_W-1:0] fid;
  logic [CNT_W-1:0] remain, idx;
  logic [15:0]     word_q;
  logic            full, hi_sel;
  logic [1:0]      lkp_q;
  logic            da_done;

  wire host_hs  = host_valid && host_ready;
  wire eg_hs    = eg_valid && eg_ready;
  wire cap_pt   = (idx == DA_END) || eg_last;
  wire [CNT_W-1:0] cnt_field = host_word[CNT_W-1:0];

  assign host_ready = (st != S_DATA) || !full;
  assign eg_valid   = (st == S_DATA) && full;
  assign eg_byte    = hi_sel ? word_q[15:8] : word_q[7:0];
  assign eg_last    = eg_valid && (remain == ONE);
  assign eg_port    = (mask != 2'b00) ? mask : (da_done ? lkp_q : lkp_port);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_CTRL;
      req_irq   <= 1'b0;
      mask      <= 2'b00;
      fid       <= '0;
      remain    <= '0;
      idx       <= '0;
      word_q    <= '0;
      full      <= 1'b0;
      hi_sel    <= 1'b0;
      lkp_q     <= 2'b00;
      da_done   <= 1'b0;
      tx_status <= '0;
      tx_irq    <= 1'b0;
      cnt_err   <= 1'b0;
    end else begin
      tx_irq <= 1'b0;
      case (st)
        S_CTRL: if (host_hs) begin
          req_irq <= host_word[IRQ_BIT];
          mask    <= host_word[MASK_LO+1:MASK_LO];
          fid     <= host_word[ID_W-1:0];
          st      <= S_CNT;
        end
        S_CNT: if (host_hs) begin
          if (cnt_field == '0) begin
            cnt_err <= 1'b1;
            st      <= S_CTRL;
          end else begin
            remain  <= cnt_field;
            idx     <= '0;
            da_done <= 1'b0;
            st      <= S_DATA;
          end
        end
        default: begin
          if (host_hs) begin
            word_q <= host_word;
            full   <= 1'b1;
            hi_sel <= 1'b0;
          end
          if (eg_hs) begin
            remain <= remain - ONE;
            idx    <= idx + ONE;
            if (cap_pt && !da_done) begin
              lkp_q   <= lkp_port;
              da_done <= 1'b1;
            end
            if (remain == ONE) begin
              full      <= 1'b0;
              hi_sel    <= 1'b0;
              st        <= S_CTRL;
              tx_status <= fid;
              tx_irq    <= req_irq;
            end else if (!hi_sel) begin
              hi_sel <= 1'b1;
            end else begin
              full   <= 1'b0;
              hi_sel <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  AST_EG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    eg_valid && !eg_ready |=> eg_valid && $stable(eg_byte) && $stable(eg_last)); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(eg_hs && eg_last)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |=> cnt_err); // R8
  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(eg_hs && eg_last) |=> $stable(tx_status)); // R6
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    eg_hs && eg_last |=> !eg_valid); // R3

endmodule

// File: tb/tx_frame_dispatch_tb_top.sv
module tx_frame_dispatch_tb_top;
  localparam int NF = 40;

  logic clk = 0, rst_n = 0;
  logic host_valid = 0, eg_ready = 0;
  logic [15:0] host_word = 0;
  logic [1:0] lkp_port = 0;
  logic host_ready, eg_valid, eg_last, tx_irq, cnt_err;
  logic [7:0] eg_byte;
  logic [1:0] eg_port;
  logic [5:0] tx_status;

  always #10 clk = ~clk;

  tx_frame_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_word(host_word), .lkp_port(lkp_port), .eg_valid(eg_valid), .eg_ready(eg_ready),
    .eg_byte(eg_byte), .eg_last(eg_last), .eg_port(eg_port), .tx_status(tx_status),
    .tx_irq(tx_irq), .cnt_err(cnt_err));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] f_ctrl [NF];
  logic [15:0] f_cntw [NF];
  int f_off [NF];
  logic [7:0] pay [0:8191];
  int nz_total = 0, frames_done = 0, bytes_out = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cnt_of(int i);
    return int'(f_cntw[i][10:0]);
  endfunction

  function automatic int cap_idx(int c);
    return (c - 1 < 5) ? c - 1 : 5;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic put_word(logic [15:0] w);
    @(negedge clk); #1;
    host_valid = 1; host_word = w;
    while (!host_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (($urandom % 3) == 0) begin
      @(negedge clk); #1; host_valid = 0;
      repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  task automatic send_frame(int i);
    int c = cnt_of(i);
    put_word(f_ctrl[i]);
    put_word(f_cntw[i]);
    for (int k = 0; k < (c + 1) / 2; k++) begin
      logic [7:0] hi = (2 * k + 1 < c) ? pay[f_off[i] + 2 * k + 1] : 8'($urandom);
      put_word({hi, pay[f_off[i] + 2 * k]});
    end
    @(negedge clk); #1; host_valid = 0;
  endtask

  task automatic host_run();
    logic [5:0] st_before;
    for (int i = 0; i < NF; i++) begin
      if (cnt_of(i) == 0) begin
        while (frames_done < i) @(negedge clk);
        repeat (3) @(negedge clk);
        #3;
        chk(cnt_err == 0, "R8", "cnt_err before zero frame", cnt_err, 0);
        st_before = tx_status;
        begin
          int b0 = bytes_out;
          send_frame(i);
          repeat (4) @(negedge clk);
          #3;
          chk(cnt_err == 1, "R8", "cnt_err after zero frame", cnt_err, 1);
          chk(bytes_out == b0 && !eg_valid, "R8", "bytes sent for zero frame", bytes_out - b0, 0);
          chk(tx_status == st_before, "R8", "status after zero frame", tx_status, st_before);
        end
      end else begin
        send_frame(i);
      end
    end
  endtask

  task automatic sink_run();
    int fi = 0, bi = 0;
    bit prev_hs = 0, prev_req = 0, stall = 0;
    logic [5:0] prev_id = 0;
    logic [7:0] stall_byte = 0;
    logic [1:0] capv = 0;
    int tail = 0;
    while (tail < 3) begin
      @(negedge clk); #2;
      eg_ready = ($urandom % 4) != 0;
      lkp_port = 2'($urandom);
      #1;
      chk(tx_irq == (prev_hs && prev_req), "R7", "tx_irq", tx_irq, prev_hs && prev_req);
      if (prev_hs) chk(tx_status == prev_id, "R6", "tx_status", tx_status, prev_id);
      if (stall) chk(eg_valid && eg_byte == stall_byte, "R10", "held byte", eg_byte, stall_byte);
      prev_hs = 0;
      if (eg_valid) begin
        int c;
        logic [1:0] m;
        bit rsv;
        while (fi < NF && cnt_of(fi) == 0) fi++;
        if (fi >= NF) begin
          chk(0, "R3", "byte beyond last frame", eg_byte, 0);
          break;
        end
        c = cnt_of(fi);
        m = f_ctrl[fi][9:8];
        rsv = (f_ctrl[fi][14:10] != 0) || (f_ctrl[fi][7:6] != 0) || (f_cntw[fi][15:11] != 0);
        chk(!host_ready, "R1", "host_ready while word pending", host_ready, 0);
        chk(eg_byte == pay[f_off[fi] + bi], rsv ? "R9" : "R2", "byte value", eg_byte, pay[f_off[fi] + bi]);
        chk(eg_last == (bi == c - 1), rsv ? "R9" : "R3", "last marker", eg_last, bi == c - 1);
        if (m != 0) chk(eg_port == m, "R4", "mask port", eg_port, m);
        else begin
          if (bi == cap_idx(c)) capv = lkp_port;
          if (bi > 5 || bi == c - 1) chk(eg_port == capv, "R5", "lookup port", eg_port, capv);
        end
        stall = !eg_ready;
        stall_byte = eg_byte;
        if (eg_ready) begin
          bytes_out++;
          if (bi == c - 1) begin
            prev_hs = 1; prev_req = f_ctrl[fi][15]; prev_id = f_ctrl[fi][5:0];
            frames_done = fi + 1;
            fi++; bi = 0;
          end else bi++;
        end
      end else stall = 0;
      if (fi >= NF || (frames_done > 0 && frames_done >= NF)) tail++;
      else begin
        int j = fi;
        while (j < NF && cnt_of(j) == 0) j++;
        if (j >= NF) tail++;
      end
    end
  endtask

  initial begin
    int off = 0;
    int dsz [8] = '{1, 2, 5, 6, 7, 2047, 0, 3};
    logic [15:0] dctl [8] = '{16'h8105, 16'h0202, 16'h000A, 16'h8013, 16'h0021, 16'h833F, 16'h8011, 16'h7DC7};
    void'($urandom(32'd20240611));
    for (int i = 0; i < NF; i++) begin
      if (i < 8) begin
        f_ctrl[i] = dctl[i];
        f_cntw[i] = (i == 7) ? (16'hF800 | 16'(dsz[i])) : 16'(dsz[i]);
      end else begin
        f_ctrl[i] = 16'($urandom);
        f_cntw[i] = {5'($urandom), 11'(1 + $urandom % 64)};
      end
      f_off[i] = off;
      for (int b = 0; b < cnt_of(i); b++) pay[off + b] = 8'($urandom);
      off += cnt_of(i);
      if (cnt_of(i) != 0) nz_total++;
    end
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #3;
    chk(host_ready == 1, "R11", "host_ready", host_ready, 1);
    chk(eg_valid == 0, "R11", "eg_valid", eg_valid, 0);
    chk(tx_irq == 0, "R11", "tx_irq", tx_irq, 0);
    chk(tx_status == 0, "R11", "tx_status", tx_status, 0);
    chk(cnt_err == 0, "R11", "cnt_err", cnt_err, 0);
    fork
      host_run();
      sink_run();
    join
    chk(frames_done == NF && bytes_out == off, "R3", "total bytes", bytes_out, off);
    chk(cnt_err == 1, "R8", "cnt_err sticky at end", cnt_err, 1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d frames", frames_done, NF);
    finish_run();
  end
endmodule